// File: doc/BRIEF.md
# Operand Bypass and Load Interlock Controller

This controller sits beside a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). The pipeline hands it the instruction word held in the decode latch each cycle. The controller decodes that word itself and keeps a shadow of the register-use information for the execute, memory and writeback stages. It does not need to be told what those stages hold. From that record it picks where each execute-stage operand comes from. It flags decode-stage reads that must take the register-file write-through. It routes a load result straight into a store that follows it directly.

A consumer placed directly behind a load cannot be served by bypassing, because the loaded value exists only at the end of the memory stage. For that case the controller raises a hold on the PC and the decode latch for exactly one cycle and turns the slot entering execute into a bubble. The older instructions keep advancing during that cycle. Only read-after-write dependences are tracked. Every instruction writes in the same single stage, so write-after-write and write-after-read orderings cannot arise.

There is no data stream through this block, so there is no valid/ready pair. `hold_front` is the back-pressure toward fetch: while it is high, the pipeline must present the same decode-latch word again on the next cycle. `id_valid` low marks the decode slot as empty.

Top module: `hz_unit`

## Requirements
- R1: While reset is held and on the first cycles after it, every forward select is 0 and `hold_front`, `kill_ex`, `wt_a`, `wt_b` and `st_data_fwd` are low.
- R2: A select value of 1 means the execute operand is taken from the execute/memory latch. It is chosen when the instruction now in the memory stage is a non-load that writes the register the execute-stage instruction reads (rs for operand A, bits 25..21; rt for operand B, bits 20..16).
- R3: A select value of 2 means the operand is taken from the memory/writeback latch. It is chosen when the writeback-stage instruction writes the register read and the memory-stage instruction does not.
- R4: When both the memory and the writeback stages write the register read, the select is 1 (the younger result wins).
- R5: Register 0 is never a producer. Selects stay 0 and write-through flags stay low for it, even after an instruction that names it as destination.
- R6: When the decode instruction reads as an ALU source (rs, or rt of a non-store) the nonzero register that a load now in execute writes, `hold_front` and `kill_ex` are high for exactly one cycle. The held instruction later gets select 2 from the writeback stage. An empty decode slot never causes a hold.
- R7: The destination is bits 15..11 for opcode 0 (register-register) and bits 20..16 for every other writing opcode (immediate ALU and load 0x23).
- R8: `wt_a` / `wt_b` go high when the writeback-stage instruction writes the decode instruction's rs / rt.
- R9: A store (opcode 0x2B) whose data register rt is written by the load directly ahead causes no hold. Two cycles later, with the store in memory and the load in writeback, `st_data_fwd` is high.
- R10: Stores (0x2B) and branches (0x04) write nothing. A later reader of their rt field gets no forward and no write-through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| id_valid | input | 1 | Decode latch holds a real instruction |
| id_instr | input | 32 | Instruction word in the decode latch |
| hold_front | output | 1 | Freeze PC and decode latch this cycle |
| kill_ex | output | 1 | Load a no-op into the execute latch this cycle |
| fwd_a_sel | output | 2 | Execute operand A source: 0 register, 1 EX/MEM, 2 MEM/WB |
| fwd_b_sel | output | 2 | Execute operand B source, same coding |
| wt_a | output | 1 | Decode rs read takes the writeback value |
| wt_b | output | 1 | Decode rt read takes the writeback value |
| st_data_fwd | output | 1 | Memory-stage store data taken from the writeback load |

## Verification
Short register-register chains place a producer one, two and both one and two slots ahead of a reader. This separates the two bypass sources and the priority between them. It also places the producer three slots ahead, which isolates write-through. Immediate and register-register producers with decoy values in the unused destination field show whether the destination is taken from the right bit range. Load streams are aimed at operand A, operand B, register 0, a store's base and a store's data. Together they separate the real interlock from the stall-free store case. Stores and empty decode slots that name a live register check that writing is inferred only from the opcode and the valid flag.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int REG_W = 5;

  localparam logic [5:0] OP_RR    = 6'h00;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2B;
  localparam logic [5:0] OP_BRNCH = 6'h04;

  typedef enum logic [1:0] {
    SRC_RF    = 2'd0,
    SRC_EXMEM = 2'd1,
    SRC_MEMWB = 2'd2
  } src_e;

  typedef struct packed {
    logic [REG_W-1:0] rs;
    logic [REG_W-1:0] rt;
    logic [REG_W-1:0] dst;
    logic             use_rs;
    logic             use_rt;
    logic             wr;
    logic             ld;
    logic             st;
  } slot_t;

  // true when a writing producer feeds register r of a reader that uses it
  function automatic logic feeds(logic wr, logic [REG_W-1:0] dst,
                                 logic used, logic [REG_W-1:0] r);
    return used && wr && (dst != '0) && (dst == r);
  endfunction
endpackage

// File: rtl/hz_decode.sv
module hz_decode
  import hz_pkg::*;
#(
  parameter int INSTR_W = 32
) (
  input  logic               valid,
  input  logic [INSTR_W-1:0] instr,
  output slot_t              slot
);
  localparam int OP_LSB = INSTR_W - 6;

  logic [5:0] op;
  logic       unused_low;

  assign op         = instr[INSTR_W-1:OP_LSB];
  assign unused_low = ^instr[10:0];

  always_comb begin
    slot    = '0;
    slot.rs = instr[25:21];
    slot.rt = instr[20:16];
    if (valid) begin
      unique case (op)
        OP_RR: begin
          slot.use_rs = 1'b1;
          slot.use_rt = 1'b1;
          slot.wr     = 1'b1;
          slot.dst    = instr[15:11];
        end
        OP_LOAD: begin
          slot.use_rs = 1'b1;
          slot.wr     = 1'b1;
          slot.ld     = 1'b1;
          slot.dst    = instr[20:16];
        end
        OP_STORE: begin
          slot.use_rs = 1'b1;
          slot.use_rt = 1'b1;
          slot.st     = 1'b1;
        end
        OP_BRNCH: begin
          slot.use_rs = 1'b1;
          slot.use_rt = 1'b1;
        end
        default: begin
          slot.use_rs = 1'b1;
          slot.wr     = 1'b1;
          slot.dst    = instr[20:16];
        end
      endcase
    end
  end
endmodule

// File: rtl/hz_track.sv
module hz_track
  import hz_pkg::*;
#(
  parameter int N_STAGES = 3
) (
  input  logic  clk,
  input  logic  rst_n,
  input  slot_t id_slot,
  input  logic  kill,
  output slot_t ex_q,
  output slot_t mem_q,
  output slot_t wb_q
);
  slot_t pipe_q [N_STAGES];

  for (genvar i = 0; i < N_STAGES; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n)    pipe_q[i] <= '0;
        else if (kill) pipe_q[i] <= '0;
        else           pipe_q[i] <= id_slot;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (!rst_n) pipe_q[i] <= '0;
        else        pipe_q[i] <= pipe_q[i-1];
      end
    end
  end

  assign ex_q  = pipe_q[0];
  assign mem_q = pipe_q[1];
  assign wb_q  = pipe_q[N_STAGES-1];

  // a killed slot enters execute as an empty no-op
  assert_bubble_R6: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> (ex_q == '0));
  // the memory stage holds what execute held a cycle before
  assert_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (mem_q == $past(ex_q)));
endmodule

// File: rtl/hz_operand_sel.sv
module hz_operand_sel
  import hz_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] src,
  input  logic             used,
  input  logic             mem_wr,
  input  logic             mem_ld,
  input  logic [REG_W-1:0] mem_dst,
  input  logic             wb_wr,
  input  logic [REG_W-1:0] wb_dst,
  output src_e             sel
);
  logic mem_hit, wb_hit;

  assign mem_hit = feeds(mem_wr, mem_dst, used, src);
  assign wb_hit  = feeds(wb_wr, wb_dst, used, src);

  always_comb begin
    if (mem_hit)     sel = mem_ld ? SRC_RF : SRC_EXMEM; // load data not ready yet
    else if (wb_hit) sel = SRC_MEMWB;
    else             sel = SRC_RF;
  end

  assert_no_zero_fwd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel != SRC_RF) |-> (src != '0));
  assert_legal_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sel != 2'd3);
endmodule

// File: rtl/hz_unit.sv
module hz_unit
  import hz_pkg::*;
#(
  parameter int INSTR_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               id_valid,
  input  logic [INSTR_W-1:0] id_instr,
  output logic               hold_front,
  output logic               kill_ex,
  output logic [1:0]         fwd_a_sel,
  output logic [1:0]         fwd_b_sel,
  output logic               wt_a,
  output logic               wt_b,
  output logic               st_data_fwd
);
  localparam int N_OPND = 2;

  slot_t id_slot, ex_q, mem_q, wb_q;
  logic  load_use;
  src_e  sel   [N_OPND];
  logic  unused_fields;

  hz_decode #(.INSTR_W(INSTR_W)) u_dec (
    .valid (id_valid),
    .instr (id_instr),
    .slot  (id_slot)
  );

  // a load in execute blocks a decode reader of its result, except store data
  assign load_use = ex_q.ld &&
                    (feeds(ex_q.wr, ex_q.dst, id_slot.use_rs, id_slot.rs) ||
                     feeds(ex_q.wr, ex_q.dst, id_slot.use_rt && !id_slot.st, id_slot.rt));

  hz_track #(.N_STAGES(3)) u_trk (
    .clk     (clk),
    .rst_n   (rst_n),
    .id_slot (id_slot),
    .kill    (load_use),
    .ex_q    (ex_q),
    .mem_q   (mem_q),
    .wb_q    (wb_q)
  );

  for (genvar k = 0; k < N_OPND; k++) begin : g_opnd
    hz_operand_sel u_sel (
      .clk     (clk),
      .rst_n   (rst_n),
      .src     ((k == 0) ? ex_q.rs : ex_q.rt),
      .used    ((k == 0) ? ex_q.use_rs : ex_q.use_rt),
      .mem_wr  (mem_q.wr),
      .mem_ld  (mem_q.ld),
      .mem_dst (mem_q.dst),
      .wb_wr   (wb_q.wr),
      .wb_dst  (wb_q.dst),
      .sel     (sel[k])
    );
  end

  assign fwd_a_sel   = sel[0];
  assign fwd_b_sel   = sel[1];
  assign hold_front  = load_use;
  assign kill_ex     = load_use;
  assign wt_a        = feeds(wb_q.wr, wb_q.dst, id_slot.use_rs, id_slot.rs);
  assign wt_b        = feeds(wb_q.wr, wb_q.dst, id_slot.use_rt, id_slot.rt);
  assign st_data_fwd = mem_q.st && wb_q.ld && feeds(wb_q.wr, wb_q.dst, 1'b1, mem_q.rt);

  assign unused_fields = ^{ex_q.st, mem_q.rs, mem_q.use_rs, mem_q.use_rt,
                           wb_q.rs, wb_q.rt, wb_q.use_rs, wb_q.use_rt, wb_q.st};

  // the interlock never lasts more than one cycle
  assert_single_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hold_front |=> !hold_front);
  // a store fed from a load never paid a stall on its way
  assert_store_nostall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    st_data_fwd |-> !$past(hold_front, 2));
  // an empty decode slot never freezes the front end
  assert_idle_nohold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !id_valid |-> !hold_front);
endmodule

// File: tb/hz_unit_test.sv
module hz_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        id_valid = 1'b0;
  logic [31:0] id_instr = '0;
  logic        hold_front, kill_ex, wt_a, wt_b, st_data_fwd;
  logic [1:0]  fwd_a_sel, fwd_b_sel;

  int n_vec = 0;
  int n_bad = 0;

  logic [7:0] exp_q [$];
  string      tag_q [$];

  hz_unit uut (
    .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_instr(id_instr),
    .hold_front(hold_front), .kill_ex(kill_ex), .fwd_a_sel(fwd_a_sel),
    .fwd_b_sel(fwd_b_sel), .wt_a(wt_a), .wt_b(wt_b), .st_data_fwd(st_data_fwd)
  );

  always #2.5 clk = ~clk;

  function automatic logic [31:0] rr(int rd, int rs, int rt);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 11'h0};
  endfunction
  function automatic logic [31:0] ai(int rt, int rs, logic [15:0] imm);
    return {6'h08, 5'(rs), 5'(rt), imm};
  endfunction
  function automatic logic [31:0] ld(int rt, int rs);
    return {6'h23, 5'(rs), 5'(rt), 16'h0};
  endfunction
  function automatic logic [31:0] st(int rt, int rs);
    return {6'h2B, 5'(rs), 5'(rt), 16'h0};
  endfunction
  // expected {stall, sel_a, sel_b, wt_a, wt_b, st_fwd}
  function automatic logic [7:0] ex(bit s, int a, int b, bit wa, bit wb, bit sf);
    return {s, 2'(a), 2'(b), wa, wb, sf};
  endfunction

  task automatic issue(bit v, logic [31:0] ins, logic [7:0] e, string tag);
    @(posedge clk); #1;
    id_valid = v;
    id_instr = ins;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [7:0] e, got;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      got = {hold_front, fwd_a_sel, fwd_b_sel, wt_a, wt_b, st_data_fwd};
      n_vec++;
      if (got !== e || kill_ex !== hold_front) begin
        n_bad++;
        $display("FAIL %s: got %b kill=%b expected %b", t, got, kill_ex, e);
      end
    end
  end

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        #1 id_valid = 1'b1; id_instr = ld(9, 1);
        @(negedge clk);
        n_vec++;
        if ({hold_front, kill_ex, fwd_a_sel, fwd_b_sel, wt_a, wt_b, st_data_fwd} !== '0) begin
          n_bad++;
          $display("FAIL R1: outputs not idle in reset, expected all zero");
        end
        @(posedge clk); #1 id_valid = 1'b0; id_instr = '0; rst_n = 1'b1;
        issue(1, 32'h0, ex(0,0,0,0,0,0), "R1");
        // R2 / R3 / R8 chain
        issue(1, rr(1,2,3),  ex(0,0,0,0,0,0), "R2");
        issue(1, rr(4,1,5),  ex(0,0,0,0,0,0), "R2");
        issue(1, rr(6,5,1),  ex(0,1,0,0,0,0), "R2");
        issue(1, rr(7,1,9),  ex(0,0,2,1,0,0), "R3 R8");
        issue(1, 32'h0,      ex(0,0,0,0,0,0), "R8");
        // R4 priority
        issue(1, rr(8,2,2),  ex(0,0,0,0,0,0), "R4");
        issue(1, rr(8,3,3),  ex(0,0,0,0,0,0), "R4");
        issue(1, rr(9,8,8),  ex(0,0,0,0,0,0), "R4");
        issue(1, 32'h0,      ex(0,1,1,0,0,0), "R4");
        issue(1, 32'h0,      ex(0,0,0,0,0,0), "R4");
        // R5 register 0, R10 store writes nothing
        issue(1, rr(0,2,3),  ex(0,0,0,0,0,0), "R5");
        issue(1, rr(4,0,0),  ex(0,0,0,0,0,0), "R5");
        issue(1, 32'h0,      ex(0,0,0,0,0,0), "R5");
        issue(1, st(5,6),    ex(0,0,0,0,0,0), "R10");
        issue(1, rr(10,5,0), ex(0,0,0,0,0,0), "R10");
        issue(1, 32'h0,      ex(0,0,0,0,0,0), "R10");
        issue(1, rr(11,5,5), ex(0,0,0,0,0,0), "R10");
        // R7 destination field by type
        issue(1, ai(12,1,16'h6800), ex(0,0,0,0,0,0), "R7");
        issue(1, rr(2,13,12), ex(0,0,0,0,0,0), "R7");
        issue(1, 32'h0,       ex(0,0,1,0,0,0), "R7");
        issue(1, rr(14,1,15), ex(0,0,0,0,0,0), "R7");
        issue(1, rr(3,15,14), ex(0,0,0,0,0,0), "R7");
        issue(1, 32'h0,       ex(0,0,1,0,0,0), "R7");
        // R6 load-use on rs, then on rt
        issue(1, ld(20,1),    ex(0,0,0,0,0,0), "R6");
        issue(1, rr(21,20,2), ex(1,0,0,0,0,0), "R6");
        issue(1, rr(21,20,2), ex(0,0,0,0,0,0), "R6");
        issue(1, 32'h0,       ex(0,2,0,0,0,0), "R6");
        issue(1, ld(20,1),    ex(0,0,0,0,0,0), "R6");
        issue(1, rr(22,3,20), ex(1,0,0,0,0,0), "R6");
        issue(1, rr(22,3,20), ex(0,0,0,0,0,0), "R6");
        issue(1, 32'h0,       ex(0,0,2,0,0,0), "R6");
        issue(1, ld(0,1),     ex(0,0,0,0,0,0), "R5");
        issue(1, rr(5,0,0),   ex(0,0,0,0,0,0), "R5");
        issue(1, 32'h0,       ex(0,0,0,0,0,0), "R5");
        // R9 store data from preceding load
        issue(1, ld(24,1),    ex(0,0,0,0,0,0), "R9");
        issue(1, st(24,2),    ex(0,0,0,0,0,0), "R9");
        issue(1, 32'h0,       ex(0,0,0,0,0,0), "R9");
        issue(1, 32'h0,       ex(0,0,0,0,0,1), "R9");
        // store base from load still interlocks
        issue(1, ld(25,1),    ex(0,0,0,0,0,0), "R6");
        issue(1, st(3,25),    ex(1,0,0,0,0,0), "R6");
        issue(1, st(3,25),    ex(0,0,0,0,0,0), "R6");
        issue(1, 32'h0,       ex(0,2,0,0,0,0), "R6");
        issue(1, 32'h0,       ex(0,0,0,0,0,0), "R9");
        // empty decode slot never holds
        issue(1, ld(26,1),     ex(0,0,0,0,0,0), "R6");
        issue(0, rr(7,26,26),  ex(0,0,0,0,0,0), "R6");
        issue(1, 32'h0,        ex(0,0,0,0,0,0), "R6");
        repeat (3) @(posedge clk);
      end
      begin
        repeat (5000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run hung, expected completion");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule